// File: doc/BRIEF.md
# Early-Terminating Capacitor Search Selector

This block drives the switch-control word of a binary-weighted capacitor bank. It uses a successive-approximation search to find a bank setting that keeps an external analog loop inside its working window. The loop reports its condition through two window-comparator flags. The `over` flag means the bank value is too large and the `under` flag means it is too small. The search begins with only the most significant element switched in. After each trial the block waits a fixed settling interval and then samples the flags to decide the next bit. It stops as soon as neither flag is set, so a pass takes anywhere from one to eight trials.

When a pass reaches the lowest bit without finding a clean window, the block starts again from the top code and marks the event with a one-cycle pulse. While holding a good setting, the block watches the flags. If a change in frequency or setpoint pushes the analog loop out of its window, the block leaves the locked state and runs a fresh search. The flags are asynchronous to the block's clock and are synchronised inside it. Every pin is plain control or status; there is no streaming data path and so no valid/ready handshake.

Top module: `cap_sa_selector`

## Requirements
- R1: While reset is asserted and right after it, the select word is `8'h80` (only bit 7 set), `locked_o` is 0 and `restart_o` is 0.
- R2: Each trial word is held unchanged for SETTLE_CYCLES+1 clock cycles. The flags, taken after a SYNC_STAGES-flop synchroniser, are sampled only at the last of those edges.
- R3: If `over` is set at the sample, the bit under trial is cleared and the next lower bit is set.
- R4: If only `under` is set at the sample, the bit under trial stays set and the next lower bit is also set.
- R5: If both flags are clear at the sample, `locked_o` goes to 1 and the word is held unchanged for as long as both stay clear. This can happen on the first trial.
- R6: If both flags are set together, the block acts exactly as it does for `over` alone.
- R7: If a flag is still set when bit 0 is sampled, the next word is `8'h80` and `restart_o` is high for exactly that one cycle.
- R8: While locked, a flag that goes active drops `locked_o` on the third rising edge after the flag changes (SYNC_STAGES+1), reloads `8'h80` and starts a new search.
- R9: The select word is never all zeros, and a pass makes at most eight trials.
- R10: Counting rising edges from reset release (or from the resume edge), a lock reached on trial n appears exactly n*(SETTLE_CYCLES+1) edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| over_i | input | 1 | Window flag: bank value too large (asynchronous) |
| under_i | input | 1 | Window flag: bank value too small (asynchronous) |
| sel_word_o | output | WIDTH | Capacitor switch-control word |
| locked_o | output | 1 | High while halted with both flags clear |
| restart_o | output | 1 | One-cycle pulse when a full pass fails |

## Verification
Each trial result is due SETTLE_CYCLES+1 rising edges after the previous one, and the first result is counted from reset release. The bench therefore waits exactly that many edges and samples at the following falling edge. It also checks one edge earlier that the word has not yet moved. A lock on trial n is expected n*(SETTLE_CYCLES+1) edges after release, and the bench compares its own edge count with that figure. A loss of lock is due on the third edge after the bench changes the flag, and the bench samples on both sides of that edge.

// File: rtl/sas_pkg.sv
package sas_pkg;
  typedef enum logic {
    ST_SEARCH = 1'b0,
    ST_LOCK   = 1'b1
  } sas_state_e;
endpackage

// File: rtl/sas_sync.sv
module sas_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned W      = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sas_settle_timer.sv
module sas_settle_timer #(
  parameter int unsigned COUNT = 64,
  localparam int unsigned CW   = $clog2(COUNT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic done
);
  localparam logic [CW-1:0] RELOAD = CW'(COUNT);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= RELOAD;
    else if (load)       cnt <= RELOAD;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

  // R2: the settle count never leaves its programmed range
  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= RELOAD);
endmodule

// File: rtl/sas_trial_step.sv
module sas_trial_step #(
  parameter int unsigned WIDTH = 8,
  localparam int unsigned PW   = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] word,
  input  logic [PW-1:0]    bitpos,
  input  logic             too_big,
  output logic [WIDTH-1:0] next_word
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);
  logic [WIDTH-1:0] cur_mask;
  logic [WIDTH-1:0] low_mask;

  always_comb begin
    cur_mask = ONE << bitpos;
    low_mask = cur_mask >> 1;
    if (too_big) next_word = (word & ~cur_mask) | low_mask;
    else         next_word = word | low_mask;
  end
endmodule

// File: rtl/cap_sa_selector.sv
module cap_sa_selector #(
  parameter int unsigned WIDTH         = 8,
  parameter int unsigned SETTLE_CYCLES = 64,
  parameter int unsigned SYNC_STAGES   = 2,
  localparam int unsigned PW           = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             over_i,
  input  logic             under_i,
  output logic [WIDTH-1:0] sel_word_o,
  output logic             locked_o,
  output logic             restart_o
);
  import sas_pkg::*;

  localparam logic [WIDTH-1:0] TOP_WORD = {1'b1, {(WIDTH-1){1'b0}}};
  localparam logic [PW-1:0]    TOP_POS  = PW'(WIDTH - 1);

  sas_state_e       state;
  logic [PW-1:0]    bitpos;
  logic [1:0]       flags_s;
  logic             over_s, under_s, any_s;
  logic             tmr_done, tmr_load;
  logic [WIDTH-1:0] step_word;

  sas_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({over_i, under_i}), .q(flags_s)
  );
  assign over_s  = flags_s[1];
  assign under_s = flags_s[0];
  assign any_s   = over_s | under_s;

  assign tmr_load = (state == ST_LOCK) || tmr_done;

  sas_settle_timer #(.COUNT(SETTLE_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .done(tmr_done)
  );

  // over wins when both flags are set
  sas_trial_step #(.WIDTH(WIDTH)) u_step (
    .word(sel_word_o), .bitpos(bitpos), .too_big(over_s), .next_word(step_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_SEARCH;
      sel_word_o <= TOP_WORD;
      bitpos     <= TOP_POS;
      locked_o   <= 1'b0;
      restart_o  <= 1'b0;
    end else begin
      restart_o <= 1'b0;
      case (state)
        ST_SEARCH: begin
          if (tmr_done) begin
            if (!any_s) begin
              state    <= ST_LOCK;
              locked_o <= 1'b1;
            end else if (bitpos == '0) begin
              sel_word_o <= TOP_WORD;
              bitpos     <= TOP_POS;
              restart_o  <= 1'b1;
            end else begin
              sel_word_o <= step_word;
              bitpos     <= bitpos - 1'b1;
            end
          end
        end
        ST_LOCK: begin
          if (any_s) begin
            state      <= ST_SEARCH;
            locked_o   <= 1'b0;
            sel_word_o <= TOP_WORD;
            bitpos     <= TOP_POS;
          end
        end
        default: state <= ST_SEARCH;
      endcase
    end
  end

  // R9: the all-zero code is never driven
  p_nonzero_word_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sel_word_o != '0);
  // R7: a restart always presents the top code, for one cycle only
  p_restart_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
    restart_o |-> (sel_word_o == TOP_WORD && !locked_o));
  p_restart_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    restart_o |=> !restart_o);
  // R2: no word change while the settle interval runs
  p_hold_settle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SEARCH && !tmr_done) |=> $stable(sel_word_o));
  // R5: word frozen while lock is kept
  p_hold_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_o && !any_s) |=> ($stable(sel_word_o) && locked_o));
  // R8: a flag seen while locked drops lock and reloads the top code
  p_resume_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_o && any_s) |=> (!locked_o && sel_word_o == TOP_WORD));
endmodule

// File: tb/cap_sa_selector_test.sv
`timescale 1ns/1ps
module cap_sa_selector_test;
  localparam int S   = 4;
  localparam int TRL = S + 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       over_i = 1'b0, under_i = 1'b0;
  logic [7:0] sel_word_o;
  logic       locked_o, restart_o;

  int checks = 0;
  int errors = 0;

  // flag model: 0 target window, 1 forced over, 2 forced under, 3 both
  int mode = 0;
  int target = 128;
  int tol = 0;

  cap_sa_selector #(.WIDTH(8), .SETTLE_CYCLES(S), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .over_i(over_i), .under_i(under_i),
    .sel_word_o(sel_word_o), .locked_o(locked_o), .restart_o(restart_o)
  );

  always #4 clk = ~clk;

  always @(negedge clk) begin
    case (mode)
      1: begin over_i <= 1'b1; under_i <= 1'b0; end
      2: begin over_i <= 1'b0; under_i <= 1'b1; end
      3: begin over_i <= 1'b1; under_i <= 1'b1; end
      default: begin
        over_i  <= (int'(sel_word_o) > target + tol);
        under_i <= (int'(sel_word_o) + tol < target);
      end
    endcase
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int model_steps(input int t, input int tl, output int w);
    int b = 7;
    w = 128;
    for (int step = 1; step <= 8; step++) begin
      bit ov = (w > t + tl);
      bit un = (w + tl < t);
      if (!ov && !un) return step;
      if (b == 0) return 0;
      if (ov) w = (w & ~(1 << b)) | (1 << (b - 1));
      else    w = w | (1 << (b - 1));
      b--;
    end
    return 0;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(sel_word_o == 8'h80, "R1 word in reset", sel_word_o, 8'h80);
    chk(!locked_o && !restart_o, "R1 status in reset", {locked_o, restart_o}, 0);
    rst_n = 1'b1;
  endtask

  task automatic count_to_lock(output int edges);
    edges = 0;
    while (edges < 10 * TRL) begin
      @(posedge clk);
      edges++;
      @(negedge clk);
      if (locked_o) break;
    end
  endtask

  task automatic run_lock(input int t, input int tl, input string tag);
    int exp_w, exp_n, edges;
    mode = 0; target = t; tol = tl;
    exp_n = model_steps(t, tl, exp_w);
    do_reset();
    count_to_lock(edges);
    chk(edges == exp_n * TRL, {tag, " R10 lock cycle"}, edges, exp_n * TRL);
    chk(sel_word_o == exp_w[7:0], {tag, " R3/R4 locked word"}, sel_word_o, exp_w);
    repeat (10) @(negedge clk);
    chk(locked_o && sel_word_o == exp_w[7:0], {tag, " R5 hold"}, sel_word_o, exp_w);
  endtask

  task automatic run_forced(input int m, input string req);
    int prev = 8'h80, expw;
    mode = m;
    do_reset();
    for (int k = 1; k <= 8; k++) begin
      repeat (S) @(posedge clk);
      @(negedge clk);
      chk(sel_word_o == prev[7:0], "R2 word held during settle", sel_word_o, prev);
      @(posedge clk);
      @(negedge clk);
      if (k == 8) begin
        chk(sel_word_o == 8'h80 && restart_o, "R7 restart after bit 0",
            {restart_o, sel_word_o}, 9'h180);
      end else begin
        if (m == 2) expw = (8'hFF << (7 - k)) & 8'hFF;
        else        expw = 8'h80 >> k;
        chk(sel_word_o == expw[7:0] && !restart_o, req, sel_word_o, expw);
        prev = expw;
      end
    end
    @(negedge clk);
    chk(!restart_o, "R7 pulse lasts one cycle", restart_o, 0);
    chk(sel_word_o != 0, "R9 word nonzero", sel_word_o, 1);
  endtask

  task automatic run_resume(input int t1, input int t2);
    int exp_w, exp_n, edges;
    run_lock(t1, 0, "resume-pre");
    @(posedge clk);
    #1 target = t2;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(locked_o, "R8 lock kept before sync delay", locked_o, 1);
    @(posedge clk);
    @(negedge clk);
    chk(!locked_o && sel_word_o == 8'h80, "R8 resume reload",
        {locked_o, sel_word_o}, 8'h80);
    exp_n = model_steps(t2, 0, exp_w);
    edges = 0;
    while (edges < 10 * TRL) begin
      @(posedge clk);
      edges++;
      @(negedge clk);
      if (locked_o) break;
    end
    chk(edges == exp_n * TRL, "R8/R10 relock cycle", edges, exp_n * TRL);
    chk(sel_word_o == exp_w[7:0], "R8 relocked word", sel_word_o, exp_w);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    run_lock(128, 0, "R5 first-trial lock");
    run_lock(1, 0, "R9 eight-trial pass");
    run_lock(8'h55, 0, "mixed");
    run_lock(200, 2, "window");
    run_forced(1, "R3 over clears bit");
    run_forced(2, "R4 under keeps bit");
    run_forced(3, "R6 both acts as over");
    run_resume(8'h60, 8'hB3);
    for (int i = 0; i < 20; i++) begin
      int t = int'($urandom % 255) + 1;
      int tl = int'($urandom % 4);
      run_lock(t, tl, "random");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule